// File: doc/BRIEF.md
# Hardware Performance Counter Bank

This block holds a set of event counters that a processor's control-register logic reads and writes. Each counter has its own event-select mask. In every clock cycle each counter looks at a vector of event strobes. The counter adds exactly one when at least one strobe selected by its mask is high and its bit in a shared inhibit register is clear. Counter values are kept at a width set by a parameter and are reached as a low 32-bit word and a high 32-bit word.

Only machine-mode requests may reach any register in the block's address window. A request from a lower privilege level in that window raises an illegal-access flag in the same cycle, returns zero and changes nothing. A register that would grant lower-privilege access to the counters is present in the map, but it always reads zero and ignores writes. Reads are combinational. Writes take effect at the next rising clock edge.

Top module: `perf_counter_bank`

## Requirements
- R1: After reset every counter word, every event-select register and the inhibit register read zero.
- R2: A present counter at slot s adds exactly one at a clock edge when (events_i & select[s]) is non-zero and inhibit bit s is clear. Several matching strobes still add only one.
- R3: A counter holds its value at an edge when no selected strobe is high, or when its inhibit bit (bit s of the inhibit register) is set.
- R4: The address map is as follows. Low word of slot s is at 0x100+s. High word is at 0x120+s. Event select is at 0x140+s, in bits [NUM_EVT-1:0]. The inhibit register is at 0x160. The user-enable register is at 0x161. Slots run from 3 to 3+NUM_CNT-1. Read data follows the address in the same cycle.
- R5: A machine-mode write to a counter word at an edge where that counter would also increment stores the written value and drops the increment.
- R6: When a counter's low word steps from 0xFFFFFFFF to zero, its high word rises by one.
- R7: Counter bits at and above CNT_WIDTH read zero and ignore written ones. A counter at its all-ones value wraps to zero on the next increment.
- R8: A request with acc_priv other than 2'b11 (machine) to any address from 0x100 to 0x17F asserts acc_illegal in the same cycle, returns zero read data and changes no register.
- R9: The user-enable register at 0x161 always reads zero, and writes to it have no effect.
- R10: Slots that are not present read zero and ignore writes. Inhibit bits for absent slots and bits 2:0 read zero.
- R11: With CNT_WIDTH set to 0, every counter word reads zero whatever events arrive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| events_i | input | NUM_EVT | Event strobes sampled every cycle |
| acc_valid | input | 1 | Register access request |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 12 | Register address |
| acc_priv | input | 2 | Privilege of requester, 2'b11 = machine |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Combinational read data |
| acc_illegal | output | 1 | Request from a lower privilege level inside the window |

## Verification
On every cycle the assertions check the following. A counter changes by at most one step. A write overrides a coincident increment. A counter stays frozen when it is idle or inhibited. Bits above the width stay clear. An illegal request returns zero and leaves the inhibit state unchanged. The bench scenarios have to show the rest: the address decode and slot mapping, carry from the low word into the high word, wrap at the configured width, and the width-zero build. A reference model driven by random traffic with mixed privilege levels checks that all counters agree over long runs.

// File: rtl/perf_pkg.sv
package perf_pkg;

    localparam logic [1:0] PRIV_MACHINE = 2'b11;
    localparam int         FIRST_SLOT   = 3;
    localparam int         MAX_SLOTS    = 29;

    // 0x100..0x17F window, selected by addr[11:7]
    localparam logic [4:0] WINDOW_TAG   = 5'b00010;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_CNT_LO,
        RG_CNT_HI,
        RG_EVSEL,
        RG_INHIBIT,
        RG_USER_EN
    } perf_region_e;

endpackage

// File: rtl/perf_csr_decode.sv
module perf_csr_decode
    import perf_pkg::*;
(
    input  logic         valid_i,
    input  logic         write_i,
    input  logic [11:0]  addr_i,
    input  logic [1:0]   priv_i,
    output perf_region_e region_o,
    output logic [4:0]   slot_o,
    output logic         rd_en_o,
    output logic         wr_en_o,
    output logic         illegal_o
);

    logic in_window;
    logic is_machine;

    always_comb begin
        in_window  = (addr_i[11:7] == WINDOW_TAG);
        is_machine = (priv_i == PRIV_MACHINE);
        slot_o     = addr_i[4:0];

        case (addr_i[6:5])
            2'b00:   region_o = RG_CNT_LO;
            2'b01:   region_o = RG_CNT_HI;
            2'b10:   region_o = RG_EVSEL;
            default: begin
                if (addr_i[4:0] == 5'd0)      region_o = RG_INHIBIT;
                else if (addr_i[4:0] == 5'd1) region_o = RG_USER_EN;
                else                          region_o = RG_NONE;
            end
        endcase

        rd_en_o   = valid_i && in_window && is_machine;
        wr_en_o   = rd_en_o && write_i;
        illegal_o = valid_i && in_window && !is_machine;
    end

endmodule

// File: rtl/perf_counter_slice.sv
module perf_counter_slice #(
    parameter int CNT_WIDTH = 40,
    parameter int NUM_EVT   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] events_i,
    input  logic               inhibit_i,
    input  logic               wr_lo_i,
    input  logic               wr_hi_i,
    input  logic               wr_sel_i,
    input  logic [31:0]        wdata_i,
    output logic [63:0]        cnt_o,
    output logic [NUM_EVT-1:0] sel_o
);

    localparam logic [63:0] WMASK = (CNT_WIDTH >= 64) ? {64{1'b1}}
                                  : ((64'd1 << CNT_WIDTH) - 64'd1);

    typedef struct packed {
        logic [63:0]        cnt;
        logic [NUM_EVT-1:0] sel;
    } slice_state_t;

    slice_state_t st_d, st_q;
    logic         step;

    always_comb begin
        st_d = st_q;
        step = (|(events_i & st_q.sel)) && !inhibit_i;

        if (wr_lo_i)
            st_d.cnt = {st_q.cnt[63:32], wdata_i} & WMASK;
        else if (wr_hi_i)
            st_d.cnt = {wdata_i, st_q.cnt[31:0]} & WMASK;
        else if (step)
            st_d.cnt = (st_q.cnt + 64'd1) & WMASK;

        if (wr_sel_i)
            st_d.sel = wdata_i[NUM_EVT-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign sel_o = st_q.sel;

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo_i |=> cnt_o[31:0] == ($past(wdata_i) & WMASK[31:0]));  // R5

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_lo_i && !wr_hi_i && !inhibit_i && (events_i & sel_o) != '0)
        |=> cnt_o == (($past(cnt_o) + 64'd1) & WMASK));  // R2

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_lo_i && !wr_hi_i && (inhibit_i || (events_i & sel_o) == '0))
        |=> cnt_o == $past(cnt_o));  // R3

    AST_ABOVE_WIDTH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o & ~WMASK) == 64'd0);  // R7

endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
    import perf_pkg::*;
#(
    parameter int NUM_CNT   = 4,
    parameter int CNT_WIDTH = 40,
    parameter int NUM_EVT   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] events_i,
    input  logic               acc_valid,
    input  logic               acc_write,
    input  logic [11:0]        acc_addr,
    input  logic [1:0]         acc_priv,
    input  logic [31:0]        acc_wdata,
    output logic [31:0]        acc_rdata,
    output logic               acc_illegal
);

    localparam int LAST_SLOT = FIRST_SLOT + NUM_CNT - 1;

    typedef struct packed {
        logic [NUM_CNT-1:0] inh;
    } bank_state_t;

    bank_state_t st_d, st_q;

    perf_region_e dec_region;
    logic [4:0]   dec_slot;
    logic         dec_rd, dec_wr, dec_illegal;

    logic [NUM_CNT-1:0][63:0]        cnt_w;
    logic [NUM_CNT-1:0][NUM_EVT-1:0] sel_w;

    perf_csr_decode u_decode (
        .valid_i   (acc_valid),
        .write_i   (acc_write),
        .addr_i    (acc_addr),
        .priv_i    (acc_priv),
        .region_o  (dec_region),
        .slot_o    (dec_slot),
        .rd_en_o   (dec_rd),
        .wr_en_o   (dec_wr),
        .illegal_o (dec_illegal)
    );

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        localparam logic [4:0] SLOT = 5'(FIRST_SLOT + i);
        logic hit_slot;
        assign hit_slot = dec_wr && (dec_slot == SLOT);

        perf_counter_slice #(
            .CNT_WIDTH (CNT_WIDTH),
            .NUM_EVT   (NUM_EVT)
        ) u_slice (
            .clk       (clk),
            .rst_n     (rst_n),
            .events_i  (events_i),
            .inhibit_i (st_q.inh[i]),
            .wr_lo_i   (hit_slot && dec_region == RG_CNT_LO),
            .wr_hi_i   (hit_slot && dec_region == RG_CNT_HI),
            .wr_sel_i  (hit_slot && dec_region == RG_EVSEL),
            .wdata_i   (acc_wdata),
            .cnt_o     (cnt_w[i]),
            .sel_o     (sel_w[i])
        );
    end

    always_comb begin
        st_d = st_q;
        if (dec_wr && dec_region == RG_INHIBIT)
            st_d.inh = acc_wdata[FIRST_SLOT +: NUM_CNT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        acc_rdata = '0;
        if (dec_rd) begin
            case (dec_region)
                RG_CNT_LO: for (int i = 0; i < NUM_CNT; i++)
                    if (dec_slot == 5'(FIRST_SLOT + i)) acc_rdata = cnt_w[i][31:0];
                RG_CNT_HI: for (int i = 0; i < NUM_CNT; i++)
                    if (dec_slot == 5'(FIRST_SLOT + i)) acc_rdata = cnt_w[i][63:32];
                RG_EVSEL:  for (int i = 0; i < NUM_CNT; i++)
                    if (dec_slot == 5'(FIRST_SLOT + i)) acc_rdata = 32'(sel_w[i]);
                RG_INHIBIT: acc_rdata = 32'(st_q.inh) << FIRST_SLOT;
                default:    acc_rdata = '0;
            endcase
        end
        acc_illegal = dec_illegal;
    end

    AST_ILLEGAL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        acc_illegal |-> acc_rdata == 32'd0);  // R8

    AST_ILLEGAL_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        acc_illegal |=> st_q.inh == $past(st_q.inh));  // R8

    AST_USER_EN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_addr == 12'h161) |-> acc_rdata == 32'd0);  // R9

    AST_INHIBIT_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_addr == 12'h160) |-> acc_rdata[FIRST_SLOT-1:0] == '0);  // R10

    initial begin
        assert (NUM_CNT >= 1 && NUM_CNT <= MAX_SLOTS && LAST_SLOT <= 31);
        assert (CNT_WIDTH >= 0 && CNT_WIDTH <= 64 && NUM_EVT >= 1 && NUM_EVT <= 32);
    end

endmodule

// File: tb/perf_counter_bank_test.sv
module perf_counter_bank_test;

    localparam int CLK_PERIOD = 10;
    localparam int NCNT = 4;
    localparam int NEVT = 8;
    localparam logic [63:0] MASK = (64'd1 << 40) - 64'd1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  events_i = '0;
    logic        acc_valid = 1'b0, acc_write = 1'b0;
    logic [11:0] acc_addr = '0;
    logic [1:0]  acc_priv = 2'b11;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata, rdata_w0;
    logic        acc_illegal, illegal_w0;

    int tests = 0, fails = 0;
    logic [63:0] m_cnt [NCNT];
    logic [7:0]  m_sel [NCNT];
    logic [NCNT-1:0] m_inh;

    always #(CLK_PERIOD/2) clk = ~clk;

    perf_counter_bank #(.NUM_CNT(NCNT), .CNT_WIDTH(40), .NUM_EVT(NEVT)) uut (
        .clk(clk), .rst_n(rst_n), .events_i(events_i), .acc_valid(acc_valid),
        .acc_write(acc_write), .acc_addr(acc_addr), .acc_priv(acc_priv),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .acc_illegal(acc_illegal));

    perf_counter_bank #(.NUM_CNT(1), .CNT_WIDTH(0), .NUM_EVT(NEVT)) uut_w0 (
        .clk(clk), .rst_n(rst_n), .events_i(events_i), .acc_valid(acc_valid),
        .acc_write(acc_write), .acc_addr(acc_addr), .acc_priv(acc_priv),
        .acc_wdata(acc_wdata), .acc_rdata(rdata_w0), .acc_illegal(illegal_w0));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [11:0] a, input logic [1:0] p);
        logic [31:0] r = '0;
        if (p != 2'b11 || a[11:7] != 5'b00010) return '0;
        for (int i = 0; i < NCNT; i++) begin
            if (a == 12'h100 + 12'(3 + i)) r = m_cnt[i][31:0];
            if (a == 12'h120 + 12'(3 + i)) r = m_cnt[i][63:32];
            if (a == 12'h140 + 12'(3 + i)) r = 32'(m_sel[i]);
        end
        if (a == 12'h160) r = 32'(m_inh) << 3;
        return r;
    endfunction

    // model of one clock edge for the inputs currently driven
    task automatic model_edge();
        logic wr = acc_valid && acc_write && acc_priv == 2'b11;
        logic [NCNT-1:0] inh_old = m_inh;
        for (int i = 0; i < NCNT; i++) begin
            logic [11:0] s = 12'(3 + i);
            if (wr && acc_addr == 12'h100 + s)      m_cnt[i] = {m_cnt[i][63:32], acc_wdata} & MASK;
            else if (wr && acc_addr == 12'h120 + s) m_cnt[i] = {acc_wdata, m_cnt[i][31:0]} & MASK;
            else if (!inh_old[i] && (events_i & m_sel[i]) != 0) m_cnt[i] = (m_cnt[i] + 64'd1) & MASK;
            if (wr && acc_addr == 12'h140 + s) m_sel[i] = acc_wdata[7:0];
        end
        if (wr && acc_addr == 12'h160) m_inh = acc_wdata[3 +: NCNT];
    endtask

    // one clock: inputs set in low phase, model updated after the edge
    task automatic cyc(input logic v, input logic w, input logic [11:0] a,
                       input logic [31:0] d, input logic [1:0] p, input logic [7:0] ev);
        acc_valid = v; acc_write = w; acc_addr = a; acc_wdata = d; acc_priv = p; events_i = ev;
        #1;
        if (v && p != 2'b11 && a[11:7] == 5'b00010) begin
            check("R8 illegal flag", 32'(acc_illegal), 32'd1);
            check("R8 illegal rdata", acc_rdata, 32'd0);
        end
        @(posedge clk);
        model_edge();
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; events_i = '0; acc_priv = 2'b11;
    endtask

    task automatic rd(input string req, input logic [11:0] a, input logic [1:0] p);
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a; acc_priv = p;
        #1;
        check(req, acc_rdata, exp_read(a, p));
        acc_valid = 1'b0; acc_priv = 2'b11;
    endtask

    task automatic rd_all(input string req);
        for (int i = 0; i < NCNT; i++) begin
            rd(req, 12'h100 + 12'(3 + i), 2'b11);
            rd(req, 12'h120 + 12'(3 + i), 2'b11);
            rd(req, 12'h140 + 12'(3 + i), 2'b11);
        end
        rd(req, 12'h160, 2'b11);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < NCNT; i++) begin m_cnt[i] = '0; m_sel[i] = '0; end
        m_inh = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, R9 user-enable reads zero
        rd_all("R1 reset");
        rd("R9 user-enable", 12'h161, 2'b11);

        // R4 program selects
        cyc(1, 1, 12'h143, 32'h01, 2'b11, 0);
        cyc(1, 1, 12'h144, 32'h06, 2'b11, 0);
        cyc(1, 1, 12'h145, 32'h80, 2'b11, 0);
        rd("R4 select slot 4", 12'h144, 2'b11);
        check("R4 select value", acc_rdata, 32'h06);

        // R2 two matching strobes add one
        cyc(0, 0, 0, 0, 2'b11, 8'h06);
        rd("R2 multi-match", 12'h104, 2'b11);
        check("R2 multi-match abs", acc_rdata, 32'd1);
        rd("R3 no match", 12'h103, 2'b11);

        // R3 inhibit slot 4
        cyc(1, 1, 12'h160, 32'h10, 2'b11, 0);
        cyc(0, 0, 0, 0, 2'b11, 8'h06);
        rd("R3 inhibited", 12'h104, 2'b11);
        check("R3 inhibited abs", acc_rdata, 32'd1);
        cyc(1, 1, 12'h160, 32'h0, 2'b11, 0);

        // R5 write beats increment
        cyc(1, 1, 12'h103, 32'd100, 2'b11, 8'h01);
        rd("R5 write priority", 12'h103, 2'b11);
        check("R5 write priority abs", acc_rdata, 32'd100);

        // R6 carry low into high
        cyc(1, 1, 12'h125, 32'h12, 2'b11, 0);
        cyc(1, 1, 12'h105, 32'hFFFF_FFFF, 2'b11, 0);
        cyc(0, 0, 0, 0, 2'b11, 8'h80);
        rd("R6 carry lo", 12'h105, 2'b11);
        rd("R6 carry hi", 12'h125, 2'b11);
        check("R6 carry hi abs", acc_rdata, 32'h13);

        // R7 width mask and wrap
        cyc(1, 1, 12'h125, 32'hFFFF_FFFF, 2'b11, 0);
        rd("R7 masked hi", 12'h125, 2'b11);
        check("R7 masked hi abs", acc_rdata, 32'hFF);
        cyc(1, 1, 12'h105, 32'hFFFF_FFFF, 2'b11, 0);
        cyc(0, 0, 0, 0, 2'b11, 8'h80);
        rd("R7 wrap lo", 12'h105, 2'b11);
        rd("R7 wrap hi", 12'h125, 2'b11);
        check("R7 wrap hi abs", acc_rdata, 32'h0);

        // R8 lower privilege: flagged, zero data, no effect
        cyc(1, 1, 12'h103, 32'd555, 2'b00, 0);
        cyc(1, 1, 12'h160, 32'hFFFF_FFFF, 2'b01, 0);
        rd("R8 user read", 12'h103, 2'b00);
        rd("R8 unchanged", 12'h103, 2'b11);
        check("R8 unchanged abs", acc_rdata, 32'd100);
        rd("R8 inhibit unchanged", 12'h160, 2'b11);

        // R9 user-enable ignores writes
        cyc(1, 1, 12'h161, 32'hFFFF_FFFF, 2'b11, 0);
        rd("R9 after write", 12'h161, 2'b11);
        check("R9 after write abs", acc_rdata, 32'd0);

        // R10 absent slot and inhibit low bits
        cyc(1, 1, 12'h107, 32'h1234, 2'b11, 0);
        rd("R10 absent slot", 12'h107, 2'b11);
        check("R10 absent slot abs", acc_rdata, 32'd0);
        cyc(1, 1, 12'h160, 32'hFFFF_FFFF, 2'b11, 0);
        rd("R10 inhibit bits", 12'h160, 2'b11);
        check("R10 inhibit abs", acc_rdata, 32'h78);
        cyc(1, 1, 12'h160, 32'h0, 2'b11, 0);

        // R11 width-zero build
        cyc(1, 1, 12'h103, 32'hFFFF_FFFF, 2'b11, 8'hFF);
        cyc(0, 0, 0, 0, 2'b11, 8'hFF);
        acc_valid = 1'b1; acc_addr = 12'h103; #1;
        check("R11 width-zero lo", rdata_w0, 32'd0);
        acc_addr = 12'h123; #1;
        check("R11 width-zero hi", rdata_w0, 32'd0);
        acc_valid = 1'b0;

        // random traffic against the model (R2 R3 R5 R8)
        for (int n = 0; n < 600; n++) begin
            if ($urandom % 6 == 0) begin
                logic [11:0] a;
                int k = $urandom % 4;
                a = (k == 3) ? 12'h160 : 12'h100 + 12'(k * 32) + 12'(3 + $urandom % 5);
                cyc(1, 1, a, $urandom, 2'(($urandom % 3 == 0) ? $urandom : 3), 8'($urandom));
            end else begin
                cyc(0, 0, 0, 0, 2'b11, 8'($urandom));
            end
            if (n % 100 == 99) rd_all("R2 R3 R5 random");
        end

        finish_run();
    end

endmodule